// File: doc/BRIEF.md
# Pin Interrupt and GPIO Controller

This block manages up to 128 general-purpose pins. Each pin has its own 8-bit configuration word. The word decides who owns the pin: a GPIO input, the on-chip peripheral, or a GPIO output held low or high. It also sets how the pin raises an interrupt, which of four CPU interrupt lines receives that interrupt, and whether the interrupt may wake the CPU from its idle wait.

Software reaches the block over a simple 32-bit register bus. Writes complete in one cycle. A read returns its data one cycle after the request. Wide per-pin registers span four 32-bit banks at consecutive word offsets, so pin `p` sits in bank `p >> 5` at bit `p & 31`.

Interrupt enables and peripheral ownership are never changed by read-modify-write. Each has its own set address and its own clear address. A bus interface state machine with two states, `RIF_IDLE` and `RIF_RESP`, sequences the read responses:
- `RIF_IDLE` moves to `RIF_RESP` on a read request.
- `RIF_RESP` stays in `RIF_RESP` on another read request.
- `RIF_RESP` returns to `RIF_IDLE` when no read is requested.

Top module: `pinirq_ctrl`

## Requirements
- R1: After reset every pin is a GPIO input with trigger off, line 0 and wake clear. All enables are zero. `cpu_irq`, `wake_o`, `pin_oe`, `pin_dev` and `bus_rvalid` are zero, and configuration, enable and priority reads return 0.
- R2: Configuration bits [1:0] set the pin role:
  - 0 is a GPIO input (`pin_oe`=0, `pin_dev`=0).
  - 1 hands the pin to the peripheral (`pin_dev`=1, `pin_oe`=0).
  - 2 drives the pin low (`pin_oe`=1, `pin_do`=0).
  - 3 drives the pin high (`pin_oe`=1, `pin_do`=1).
  - A configuration word is written and read at byte address 0x1000 + 4*pin, in bits [7:0].
- R3: Reading address 0x00 + 4*bank returns the synchronized level of that bank's 32 pins.
- R4: Trigger code 1 (bits [6:4]) makes the pin pending while its synchronized input is low. Code 2 makes it pending while the input is high. A level-pending bit is never latched.
- R5: Edge triggers latch a pending bit on the selected edge:
  - Code 5 latches on a falling edge.
  - Code 6 latches on a rising edge.
  - Code 7 latches on either edge.
  - A latched bit stays set until a one is written to its bit at 0x10 + 4*bank.
  - Codes 0, 3 and 4 never make a pin pending.
  - Pending bits are read at 0x20 + 4*bank.
- R6: Writing ones at 0x40 + 4*bank enables those pins. Writing ones at 0x50 + 4*bank disables them. Zero bits change nothing, and both addresses read back the current enable mask.
- R7: `cpu_irq[n]` is the OR of every pin that is pending, enabled, and has configuration bits [3:2] equal to n.
- R8: A read of 0x30 returns the lowest-numbered pin that is pending and enabled, with the pin number in bits [6:0] and bit 31 set. The read returns 0 when no such pin exists.
- R9: `wake_o` is the OR of every pending, enabled pin whose configuration bit 7 is set.
- R10: Writing ones at 0x80 + 4*bank sets those pins' role to peripheral (code 1). Writing ones at 0x90 + 4*bank returns peripheral-owned pins to GPIO input (code 0) and leaves pins in other roles untouched. Both addresses read back the peripheral-ownership mask.
- R11: `bus_rvalid` pulses high for one cycle, one clock after each read request, together with the read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NUM_PINS | Raw pad input levels |
| pin_oe | output | NUM_PINS | GPIO output enable per pin |
| pin_do | output | NUM_PINS | GPIO output value per pin |
| pin_dev | output | NUM_PINS | Pin is owned by the peripheral |
| bus_sel | input | 1 | Bus access request |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid |
| cpu_irq | output | 4 | CPU interrupt lines |
| wake_o | output | 1 | Idle wake request |

## Verification
Each result arrives a fixed number of clock edges after its stimulus:
- Configuration, ownership and enable writes take effect at the edge that samples them, so the pin outputs change one edge after the write.
- Read data arrives one edge after the request.
- An input change reaches a level-pending bit after two edges and an edge-pending bit after three. `cpu_irq` and `wake_o` follow one edge later, at three and four edges.

The bench drives on falling edges. It waits five cycles after every pin change or enable write before sampling interrupts. A monitor compares read data on the falling edge that follows each request, against values the driver queued when it issued the read.

// File: rtl/pinirq_pkg.sv
package pinirq_pkg;

    localparam int CFG_W  = 8;
    localparam int BANK_W = 32;

    typedef enum logic [1:0] {
        PC_GPIN   = 2'd0,
        PC_DEV    = 2'd1,
        PC_OUT_LO = 2'd2,
        PC_OUT_HI = 2'd3
    } pin_ctl_e;

    typedef enum logic [2:0] {
        TRIG_OFF    = 3'd0,
        TRIG_LVL_LO = 3'd1,
        TRIG_LVL_HI = 3'd2,
        TRIG_RSV3   = 3'd3,
        TRIG_RSV4   = 3'd4,
        TRIG_FALL   = 3'd5,
        TRIG_RISE   = 3'd6,
        TRIG_BOTH   = 3'd7
    } trig_e;

    typedef struct packed {
        logic       wake;
        trig_e      trig;
        logic [1:0] line;
        pin_ctl_e   ctl;
    } pin_cfg_t;

    // register group, byte address bits [7:4] of the low region
    localparam logic [3:0] GRP_PINVAL = 4'h0;
    localparam logic [3:0] GRP_PINCLR = 4'h1;
    localparam logic [3:0] GRP_PEND   = 4'h2;
    localparam logic [3:0] GRP_PRIO   = 4'h3;
    localparam logic [3:0] GRP_ENSET  = 4'h4;
    localparam logic [3:0] GRP_ENCLR  = 4'h5;
    localparam logic [3:0] GRP_DEVSET = 4'h8;
    localparam logic [3:0] GRP_DEVCLR = 4'h9;

    typedef enum logic {
        RIF_IDLE = 1'b0,
        RIF_RESP = 1'b1
    } rif_state_e;

endpackage

// File: rtl/pinirq_pin.sv
module pinirq_pin
    import pinirq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     pad_i,
    input  logic     cfg_we,
    input  pin_cfg_t cfg_wd,
    input  logic     dev_set,
    input  logic     dev_clr,
    input  logic     pend_clr,
    output pin_cfg_t cfg_q,
    output logic     level_o,
    output logic     pend_o
);
    logic     meta_q, sync_q, prev_q, edge_q;
    logic     rise, fall, is_edge, edge_hit;
    pin_cfg_t cfg_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= pad_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we)
            cfg_d = cfg_wd;
        else if (dev_set)
            cfg_d.ctl = PC_DEV;
        else if (dev_clr && cfg_q.ctl == PC_DEV)
            cfg_d.ctl = PC_GPIN;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign rise = sync_q & ~prev_q;
    assign fall = ~sync_q & prev_q;

    always_comb begin
        is_edge  = 1'b0;
        edge_hit = 1'b0;
        pend_o   = 1'b0;
        unique case (cfg_q.trig)
            TRIG_LVL_LO: pend_o = ~sync_q;
            TRIG_LVL_HI: pend_o = sync_q;
            TRIG_FALL: begin is_edge = 1'b1; edge_hit = fall;        pend_o = edge_q; end
            TRIG_RISE: begin is_edge = 1'b1; edge_hit = rise;        pend_o = edge_q; end
            TRIG_BOTH: begin is_edge = 1'b1; edge_hit = rise | fall; pend_o = edge_q; end
            TRIG_OFF, TRIG_RSV3, TRIG_RSV4: pend_o = 1'b0;
        endcase
    end

    // a new edge wins over a clear in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        edge_q <= 1'b0;
        else if (!is_edge) edge_q <= 1'b0;
        else if (edge_hit) edge_q <= 1'b1;
        else if (pend_clr) edge_q <= 1'b0;
    end

    assign level_o = sync_q;

endmodule

// File: rtl/pinirq_prienc.sv
module pinirq_prienc #(
    parameter int N     = 128,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/pinirq_regif.sv
module pinirq_regif
    import pinirq_pkg::*;
#(
    parameter int N      = 128,
    parameter int ADDR_W = 13,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_rvalid,
    input  logic [N-1:0]      pinval,
    input  logic [N-1:0]      pend,
    input  logic [N*CFG_W-1:0] cfg_flat,
    input  logic              prio_found,
    input  logic [IDX_W-1:0]  prio_idx,
    output logic [N-1:0]      en_q,
    output logic [N-1:0]      cfg_we,
    output pin_cfg_t          cfg_wd,
    output logic [N-1:0]      dev_set,
    output logic [N-1:0]      dev_clr,
    output logic [N-1:0]      pend_clr
);
    localparam int NB   = (N + BANK_W - 1) / BANK_W;
    localparam int NPAD = NB * BANK_W;

    rif_state_e         state_q, state_d;
    logic               rd_req, wr_req, low_rgn, cfg_rgn, cfg_ok;
    logic [1:0]         bank;
    logic [3:0]         grp;
    logic [IDX_W-1:0]   cfg_idx;
    logic [NPAD-1:0]    wmask;
    logic [N-1:0]       wvec, devmask;
    logic [31:0]        rd_word, rdata_q;
    logic               unused_bits;

    function automatic logic [31:0] pick_bank(input logic [NPAD-1:0] v, input logic [1:0] b);
        pick_bank = '0;
        for (int k = 0; k < NB; k++)
            if (b == 2'(k)) pick_bank = v[k*BANK_W +: BANK_W];
    endfunction

    assign rd_req  = bus_sel & ~bus_wr;
    assign wr_req  = bus_sel & bus_wr;
    assign bank    = bus_addr[3:2];
    assign grp     = bus_addr[7:4];
    assign low_rgn = ~bus_addr[12] && bus_addr[11:8] == 4'h0;
    assign cfg_rgn = bus_addr[12];
    assign cfg_idx = bus_addr[IDX_W+1:2];
    assign cfg_ok  = cfg_rgn && bus_addr[11:IDX_W+2] == '0 && int'(cfg_idx) < N;
    assign cfg_wd  = pin_cfg_t'(bus_wdata[CFG_W-1:0]);
    assign unused_bits = ^{bus_addr[1:0], bus_wdata[31:CFG_W]};

    always_comb begin
        wmask = '0;
        for (int k = 0; k < NB; k++)
            if (bank == 2'(k)) wmask[k*BANK_W +: BANK_W] = bus_wdata;
    end
    assign wvec = wmask[N-1:0];

    always_comb begin
        for (int i = 0; i < N; i++)
            cfg_we[i] = wr_req && cfg_ok && cfg_idx == IDX_W'(i);
    end

    assign dev_set  = (wr_req && low_rgn && grp == GRP_DEVSET) ? wvec : '0;
    assign dev_clr  = (wr_req && low_rgn && grp == GRP_DEVCLR) ? wvec : '0;
    assign pend_clr = (wr_req && low_rgn && grp == GRP_PINCLR) ? wvec : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= '0;
        else if (wr_req && low_rgn && grp == GRP_ENSET) en_q <= en_q | wvec;
        else if (wr_req && low_rgn && grp == GRP_ENCLR) en_q <= en_q & ~wvec;
    end

    always_comb begin
        for (int i = 0; i < N; i++)
            devmask[i] = cfg_flat[i*CFG_W +: 2] == PC_DEV;
    end

    always_comb begin
        rd_word = '0;
        if (cfg_ok) begin
            rd_word[CFG_W-1:0] = cfg_flat[cfg_idx*CFG_W +: CFG_W];
        end else if (low_rgn) begin
            unique case (grp)
                GRP_PINVAL:             rd_word = pick_bank(NPAD'(pinval), bank);
                GRP_PEND:               rd_word = pick_bank(NPAD'(pend), bank);
                GRP_PRIO:               rd_word = prio_found ? {1'b1, (31-IDX_W)'(0), prio_idx} : '0;
                GRP_ENSET, GRP_ENCLR:   rd_word = pick_bank(NPAD'(en_q), bank);
                GRP_DEVSET, GRP_DEVCLR: rd_word = pick_bank(NPAD'(devmask), bank);
                default:                rd_word = '0;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RIF_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RIF_IDLE: if (rd_req)  state_d = RIF_RESP;
            RIF_RESP: if (!rd_req) state_d = RIF_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rdata_q <= '0;
        else if (rd_req) rdata_q <= rd_word;
    end

    // outputs
    always_comb begin
        bus_rvalid = (state_q == RIF_RESP);
        bus_rdata  = bus_rvalid ? rdata_q : '0;
    end

endmodule

// File: rtl/pinirq_ctrl.sv
module pinirq_ctrl
    import pinirq_pkg::*;
#(
    parameter int NUM_PINS = 128,
    parameter int ADDR_W   = 13
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_do,
    output logic [NUM_PINS-1:0] pin_dev,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    output logic                bus_rvalid,
    output logic [3:0]          cpu_irq,
    output logic                wake_o
);
    localparam int IDX_W = $clog2(NUM_PINS);

    pin_cfg_t                    cfg_arr [NUM_PINS];
    pin_cfg_t                    cfg_wd;
    logic [NUM_PINS*CFG_W-1:0]   cfg_flat;
    logic [NUM_PINS-1:0]         lvl_w, pend_w, en_q, hit;
    logic [NUM_PINS-1:0]         cfg_we, dev_set, dev_clr, pend_clr;
    logic                        prio_found;
    logic [IDX_W-1:0]            prio_idx;
    logic [3:0]                  irq_d;
    logic                        wake_d;

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        pinirq_pin u_pin (
            .clk      (clk),
            .rst_n    (rst_n),
            .pad_i    (pin_in[i]),
            .cfg_we   (cfg_we[i]),
            .cfg_wd   (cfg_wd),
            .dev_set  (dev_set[i]),
            .dev_clr  (dev_clr[i]),
            .pend_clr (pend_clr[i]),
            .cfg_q    (cfg_arr[i]),
            .level_o  (lvl_w[i]),
            .pend_o   (pend_w[i])
        );
        assign cfg_flat[i*CFG_W +: CFG_W] = cfg_arr[i];
        assign pin_oe[i]  = cfg_arr[i].ctl[1];
        assign pin_do[i]  = cfg_arr[i].ctl == PC_OUT_HI;
        assign pin_dev[i] = cfg_arr[i].ctl == PC_DEV;
    end

    assign hit = pend_w & en_q;

    pinirq_prienc #(.N(NUM_PINS), .IDX_W(IDX_W)) u_prienc (
        .vec   (hit),
        .found (prio_found),
        .idx   (prio_idx)
    );

    pinirq_regif #(.N(NUM_PINS), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_rvalid (bus_rvalid),
        .pinval     (lvl_w),
        .pend       (pend_w),
        .cfg_flat   (cfg_flat),
        .prio_found (prio_found),
        .prio_idx   (prio_idx),
        .en_q       (en_q),
        .cfg_we     (cfg_we),
        .cfg_wd     (cfg_wd),
        .dev_set    (dev_set),
        .dev_clr    (dev_clr),
        .pend_clr   (pend_clr)
    );

    always_comb begin
        irq_d  = '0;
        wake_d = 1'b0;
        for (int i = 0; i < NUM_PINS; i++) begin
            if (hit[i]) begin
                irq_d[cfg_arr[i].line] = 1'b1;
                if (cfg_arr[i].wake) wake_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cpu_irq <= '0;
            wake_o  <= 1'b0;
        end else begin
            cpu_irq <= irq_d;
            wake_o  <= wake_d;
        end
    end

endmodule

// File: rtl/pinirq_ctrl_chk.sv
module pinirq_ctrl_chk #(
    parameter int N = 128
) (
    input logic         clk,
    input logic         rst_n,
    input logic         bus_sel,
    input logic         bus_wr,
    input logic         bus_rvalid,
    input logic [N-1:0] pin_oe,
    input logic [N-1:0] pin_dev,
    input logic [N-1:0] en_q,
    input logic [3:0]   cpu_irq,
    input logic         wake_o
);
    // R11
    rvalid_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rvalid |-> $past(bus_sel && !bus_wr));

    // R9
    wake_implies_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_o |-> (cpu_irq != 4'b0));

    // R6
    no_irq_when_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_q) == '0) |-> (cpu_irq == 4'b0 && !wake_o));

    // R2
    role_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_oe & pin_dev) == '0);

    // R11
    rvalid_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!bus_sel) |-> !bus_rvalid);
endmodule

bind pinirq_ctrl pinirq_ctrl_chk #(.N(NUM_PINS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_wr     (bus_wr),
    .bus_rvalid (bus_rvalid),
    .pin_oe     (pin_oe),
    .pin_dev    (pin_dev),
    .en_q       (en_q),
    .cpu_irq    (cpu_irq),
    .wake_o     (wake_o)
);

// File: tb/pinirq_ctrl_tb_top.sv
module pinirq_ctrl_tb_top;
    localparam int NP = 128;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [NP-1:0] pin_in;
    logic [NP-1:0] pin_oe, pin_do, pin_dev;
    logic          bus_sel, bus_wr;
    logic [12:0]   bus_addr;
    logic [31:0]   bus_wdata, bus_rdata;
    logic          bus_rvalid;
    logic [3:0]    cpu_irq;
    logic          wake_o;

    int    vectors = 0;
    int    miscompares = 0;
    bit    done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #4 clk = ~clk;

    pinirq_ctrl #(.NUM_PINS(NP), .ADDR_W(13)) dut_i (
        .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
        .pin_oe(pin_oe), .pin_do(pin_do), .pin_dev(pin_dev),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .cpu_irq(cpu_irq), .wake_o(wake_o)
    );

    task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string tag);
        vectors++;
        if (got !== exp) begin
            miscompares++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    // driver: queue the expected word, then issue the read
    task automatic rd(input logic [12:0] a, input logic [31:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(negedge clk);
    endtask

    // monitor: pops one expected word per valid response
    initial begin
        forever begin
            @(negedge clk);
            if (bus_rvalid) begin
                if (exp_q.size() == 0) begin
                    chk(bus_rdata, 32'hxxxx_xxxx, "R11 unexpected response");
                end else begin
                    chk(bus_rdata, exp_q.pop_front(), tag_q.pop_front());
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL watchdog: run hung, got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; pin_in = '0; bus_sel = 1'b0; bus_wr = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk({28'b0, cpu_irq}, 32'h0, "R1 cpu_irq");
        chk({31'b0, wake_o}, 32'h0, "R1 wake_o");
        chk(32'(|pin_oe), 32'h0, "R1 pin_oe");
        chk(32'(|pin_dev), 32'h0, "R1 pin_dev");
        chk({31'b0, bus_rvalid}, 32'h0, "R11 idle rvalid");
        rd(13'h040, 32'h0, "R1 enable mask");
        rd(13'h1000, 32'h0, "R1 config pin0");
        rd(13'h030, 32'h0, "R1 priority");
        rd(13'h020, 32'h0, "R1 pending");

        // R2 pin roles
        wr(13'h1014, 32'h2);
        wr(13'h1018, 32'h3);
        wr(13'h101C, 32'h1);
        chk({29'b0, pin_oe[7:5]},  32'b011, "R2 oe");
        chk({29'b0, pin_do[7:5]},  32'b010, "R2 do");
        chk({29'b0, pin_dev[7:5]}, 32'b100, "R2 dev");
        rd(13'h1018, 32'h3, "R2 config readback");
        rd(13'h080, 32'h80, "R10 ownership mask");

        // R10 ownership set and clear
        wr(13'h080, 32'h200);
        chk({31'b0, pin_dev[9]}, 32'h1, "R10 set pin9");
        rd(13'h1024, 32'h1, "R10 pin9 config");
        wr(13'h090, 32'h2A0);
        chk(32'(|pin_dev), 32'h0, "R10 clear");
        chk({31'b0, pin_oe[5]}, 32'h1, "R10 clear leaves output pin");
        rd(13'h101C, 32'h0, "R10 pin7 back to input");

        // R3 pin value
        pin_in[40] = 1'b1; settle();
        rd(13'h004, 32'h100, "R3 bank1 level");
        pin_in[40] = 1'b0;

        // R4 level triggers, R7 routing
        wr(13'h1084, 32'h24);
        wr(13'h044, 32'h2);
        settle();
        chk({28'b0, cpu_irq}, 32'h0, "R4 high level idle");
        pin_in[33] = 1'b1; settle();
        chk({28'b0, cpu_irq}, 32'h2, "R7 pin33 on line1");
        rd(13'h024, 32'h2, "R4 pending high");
        pin_in[33] = 1'b0; settle();
        chk({28'b0, cpu_irq}, 32'h0, "R4 level follows input");
        wr(13'h1088, 32'h18); settle();
        rd(13'h024, 32'h4, "R4 low level pending");
        wr(13'h044, 32'h4); settle();
        chk({28'b0, cpu_irq}, 32'h4, "R7 pin34 on line2");
        pin_in[34] = 1'b1; settle();
        chk({28'b0, cpu_irq}, 32'h0, "R4 low level released");

        // R5 edge triggers
        wr(13'h1100, 32'h6C);
        wr(13'h048, 32'h1);
        pin_in[64] = 1'b1; settle();
        chk({28'b0, cpu_irq}, 32'h8, "R5 rising on line3");
        pin_in[64] = 1'b0; settle();
        chk({28'b0, cpu_irq}, 32'h8, "R5 latched");
        rd(13'h028, 32'h1, "R5 pending latched");
        wr(13'h018, 32'h1); settle();
        chk({28'b0, cpu_irq}, 32'h0, "R5 cleared");
        rd(13'h028, 32'h0, "R5 pending cleared");
        wr(13'h1104, 32'h50);
        wr(13'h048, 32'h2);
        pin_in[65] = 1'b1; settle();
        rd(13'h028, 32'h0, "R5 falling ignores rise");
        pin_in[65] = 1'b0; settle();
        rd(13'h028, 32'h2, "R5 falling latched");
        chk({28'b0, cpu_irq}, 32'h1, "R7 pin65 on line0");
        wr(13'h018, 32'h2);
        wr(13'h1108, 32'h70);
        pin_in[66] = 1'b1; settle();
        rd(13'h028, 32'h4, "R5 both rise");
        wr(13'h018, 32'h4);
        pin_in[66] = 1'b0; settle();
        rd(13'h028, 32'h4, "R5 both fall");
        wr(13'h018, 32'h4);
        wr(13'h110C, 32'h30);
        wr(13'h1110, 32'h40);
        pin_in[67] = 1'b1; pin_in[68] = 1'b1; settle();
        pin_in[67] = 1'b0; pin_in[68] = 1'b0; settle();
        rd(13'h028, 32'h0, "R5 codes 3 and 4 off");

        // R6 enable set and clear
        rd(13'h048, 32'h3, "R6 mask via set addr");
        rd(13'h058, 32'h3, "R6 mask via clear addr");
        wr(13'h048, 32'h0);
        rd(13'h048, 32'h3, "R6 zero write no effect");
        wr(13'h058, 32'h1);
        rd(13'h048, 32'h2, "R6 cleared bit");
        pin_in[64] = 1'b1; settle();
        chk({28'b0, cpu_irq}, 32'h0, "R6 disabled pin silent");
        rd(13'h028, 32'h1, "R6 pending while disabled");
        pin_in[64] = 1'b0;

        // R8 priority encoder
        wr(13'h048, 32'h1);
        rd(13'h030, 32'h8000_0040, "R8 pin64");
        pin_in[33] = 1'b1; settle();
        rd(13'h030, 32'h8000_0021, "R8 lowest pin33");
        pin_in[33] = 1'b0;
        wr(13'h018, 32'h1); settle();
        rd(13'h030, 32'h0, "R8 none pending");

        // R9 idle wake
        wr(13'h1190, 32'hA0);
        wr(13'h04C, 32'h10); settle();
        chk({31'b0, wake_o}, 32'h0, "R9 wake idle");
        pin_in[100] = 1'b1; settle();
        chk({31'b0, wake_o}, 32'h1, "R9 wake set");
        chk({28'b0, cpu_irq}, 32'h1, "R7 pin100 on line0");
        pin_in[100] = 1'b0; pin_in[33] = 1'b1; settle();
        chk({31'b0, wake_o}, 32'h0, "R9 no wake without bit7");
        chk({28'b0, cpu_irq}, 32'h2, "R7 pin33 only");

        settle();
        chk(32'(exp_q.size()), 32'h0, "R11 all reads answered");
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule